// File: doc/BRIEF.md
# Request-Grant Temporal Assertion Monitor

A synthesizable runtime checker that watches a single request/grant handshake. It enforces one temporal rule. A request that rises, meaning `req` was low in one cycle and high in the next, must be answered. Starting in the cycle after the rise, `req` may stay high for zero up to `MAX_HOLD` cycles, and `gnt` must then appear in the cycle that follows. The rule is evaluated continuously, so a new attempt may begin in any cycle.

The monitor is a nondeterministic automaton built from a short chain of one-hot stage flip-flops. Stage `i` is set while some attempt has reached cycle `i+1` of its consequent. All attempts in the same stage behave identically from then on, so one bit per stage covers any number of overlapping attempts. In the cycle an attempt is decided, the monitor registers a verdict: `pass` pulses one cycle later for an attempt that completes, and `error` pulses one cycle later for one that cannot.

Top module: `req_gnt_monitor`

## Requirements
- R1: While `rst_n` is low, all state clears and `pass` and `error` read 0. The first sampled cycle after release only records `req`. A rise of `req` between the last reset cycle and that first cycle starts no attempt.
- R2: If `gnt` is high in the first cycle after a rise of `req`, `pass` is 1 for exactly the next cycle. This holds whatever `req` is in that cycle.
- R3: If `req` is held high for 1..`MAX_HOLD` cycles after the rise without `gnt`, and `gnt` then arrives in the following cycle, `pass` pulses once, one cycle after that `gnt`.
- R4: If an attempt sees `req` low and `gnt` low before its hold budget is used up, `error` pulses for one cycle, one cycle after that sample.
- R5: If an attempt sees `MAX_HOLD` held cycles and then a cycle with `gnt` low, `error` pulses for one cycle, one cycle later.
- R6: `pass` and `error` are never high in the same cycle. Without a rise of `req` they stay low, so a steadily high or steadily low `req` produces no verdict.
- R7: Neither `pass` nor `error` is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Observed request signal |
| gnt | input | 1 | Observed grant signal |
| pass | output | 1 | One-cycle pulse: an attempt completed |
| error | output | 1 | One-cycle pulse: an attempt failed |

## Verification
The assertions assume that `req` and `gnt` are stable, synchronous samples. They also assume that the antecedent history they consult via `$past` is valid only from the second cycle after reset release. A small counter in the checker gates those properties until then. The bench meets these assumptions by driving both inputs only on the falling edge and by holding them low through every reset. It sweeps every pattern of `req`/`gnt` over six cycles, followed by a quiet tail, so every attempt either resolves or is dropped cleanly before the next reset.

// File: rtl/req_gnt_monitor.sv
module req_gnt_monitor #(
  parameter int MAX_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gnt,
  output logic pass,
  output logic error
);
  localparam int STAGES = MAX_HOLD + 1;

  logic              armed;
  logic              req_d;
  logic [STAGES-1:0] stage;
  logic [STAGES-1:0] stage_nx;
  logic              hit;
  logic              miss;

  assign stage_nx[0] = armed & ~req_d & req;

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    assign stage_nx[i] = stage[i-1] & req & ~gnt;
  end

  assign hit  = gnt & (|stage);
  assign miss = ~gnt & ((~req & (|stage)) | (req & stage[MAX_HOLD]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      req_d <= 1'b0;
      stage <= '0;
      pass  <= 1'b0;
      error <= 1'b0;
    end else begin
      armed <= 1'b1;
      req_d <= req;
      stage <= stage_nx;
      pass  <= hit;
      error <= miss;
    end
  end
endmodule

module req_gnt_monitor_sva (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic gnt,
  input logic pass,
  input logic error
);
  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!pass && !error));

  assert_fast_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2 && !$past(req, 2) && $past(req) && gnt) |=> pass);

  assert_drop_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2 && !$past(req, 2) && $past(req) && !req && !gnt) |=> error);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && error));

  assert_pass_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> !pass);

  assert_error_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
endmodule

bind req_gnt_monitor req_gnt_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .pass(pass), .error(error)
);

// File: tb/req_gnt_monitor_test.sv
`timescale 1ns/100ps
module req_gnt_monitor_test;
  localparam int HOLD = 2;
  localparam int LEN  = 6;
  localparam int TAIL = 4;
  localparam int N    = LEN + TAIL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic gnt = 1'b0;
  logic pass, error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  req_gnt_monitor #(.MAX_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .pass(pass), .error(error)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int seq, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s seq=%0d sample=%0d actual=%0b expected=%0b", tag, seq, k, act, exp);
    end
  endtask

  initial begin
    logic rq [N];
    logic gt [N];
    logic ep [N];
    logic ee [N];
    string tp [N];
    string te [N];
    for (int s = 0; s < (1 << (2 * LEN)); s++) begin
      for (int k = 0; k < N; k++) begin
        rq[k] = (k < LEN) ? s[2*k]   : 1'b0;
        gt[k] = (k < LEN) ? s[2*k+1] : 1'b0;
        ep[k] = 1'b0; ee[k] = 1'b0;
        tp[k] = "R6"; te[k] = "R6";
      end
      for (int t = 1; t < N; t++) begin
        if (!rq[t-1] && rq[t]) begin
          for (int h = 0; h <= HOLD; h++) begin
            int c;
            c = t + 1 + h;
            if (c >= N) break;
            if (gt[c]) begin
              ep[c] = 1'b1; tp[c] = (h == 0) ? "R2" : "R3";
              break;
            end
            if (!rq[c]) begin
              ee[c] = 1'b1; te[c] = "R4";
              break;
            end
            if (h == HOLD) begin
              ee[c] = 1'b1; te[c] = "R5";
              break;
            end
          end
        end
      end

      @(negedge clk);
      rst_n = 1'b0; req = 1'b0; gnt = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(pass, 1'b0, "R1", s, -1);
      check(error, 1'b0, "R1", s, -1);
      rst_n = 1'b1;
      for (int k = 0; k < N; k++) begin
        req = rq[k]; gnt = gt[k];
        @(posedge clk);
        @(negedge clk);
        check(pass, ep[k], tp[k], s, k);
        check(error, ee[k], te[k], s, k);
        if (k > 0 && ep[k-1]) check(pass, 1'b0, "R7", s, k);
        if (k > 0 && ee[k-1]) check(error, 1'b0, "R7", s, k);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule